// File: doc/BRIEF.md
# Two-Wire Register Slave with Commit Lockout

This block is a slave on a two-wire serial bus. It watches oversampled clock and data lines, and it answers by pulling the data line low or letting it float. Behind the bus sits a small register file. An internal pointer selects the register to access. After a start, the master sends an address byte. A write transaction places the pointer with its next byte and then stores data bytes. A read transaction streams registers out from the pointer for as long as the master keeps acknowledging.

Three strap inputs supply the low part of the device address, so several copies can share one bus. After a stop that closes a transaction with at least one stored data byte, the slave acts as if a slow non-volatile commit is in progress. For a programmable number of system clocks it does not answer its own address. A master can therefore poll the slave until it acknowledges again.

Top module: `twiRegSlave`

## Requirements
- R1: Out of reset the slave leaves the data line released (`sdaDriveLow` = 0), and every register reads as 0x00.
- R2: The first byte after a start or repeated start is the address byte. Bits 7..1 must equal {DEV_HI (default 4'b1010), strap[2:0]}. Bit 0 selects the direction: 1 means read, 0 means write. On a match the slave acknowledges by holding the data line low for the ninth clock.
- R3: If the address byte does not match, the slave never drives the data line and changes no register. This lasts until the next start.
- R4: In a write, the byte after the address byte loads the pointer from its low 4 bits, with 16 registers by default. Each later byte is stored at the pointer. Every byte moves most significant bit first, and the slave acknowledges each one.
- R5: The pointer steps by one after each data byte written or read, and it wraps from register 15 to register 0.
- R6: After a write that sets the pointer, the master issues a repeated start and an address byte with bit 0 = 1. The slave then shifts out the register at the pointer, most significant bit first. It sends the next register after each master ACK, and it leaves the line released after a master NACK.
- R7: A stop that closes a transaction in which at least one data byte was stored starts a window of BUSY_CYCLES system clocks. During this window the slave does not acknowledge its own address. Once the window ends, it acknowledges again.
- R8: A stop after a transaction that stored no data byte, such as the pointer-only write of a read, starts no busy window.
- R9: The slave changes its data-line drive only while the synchronized clock line is low, and it never holds the clock line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad (wired value) |
| strap | input | 3 | Low three bits of the device address |
| sdaDriveLow | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench sends address bytes that match, that differ only in the strap bits, and that arrive after the strap inputs change. This separates a correct address compare from one that ignores the strap bits or compares the wrong bits. It writes asymmetric data values (0xC6, 0x11, 0x22, 0x33) and reads them back. A bit-order reversal or a missed shift gives a different byte. A multi-byte write and a multi-byte read that both cross register 15 expose pointer-wrap faults. An address poll placed right after a data write, compared with one placed after a pointer-only write, tells the busy window apart from a missing lockout or a lockout that fires on every stop.

// File: rtl/twiPkg.sv
package twiPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACKOUT,
    ST_TX,
    ST_ACKIN
  } twiState_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_MEM,
    BK_DATA
  } byteKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic rxShift;
    logic txLoad;
    logic txShift;
    logic ptrLoad;
    logic regWrite;
    logic busyArm;
  } dpStrobe_t;

  // bus events decoded by the datapath
  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
    logic sdaBit;
    logic sclLevel;
  } busEvent_t;

endpackage

// File: rtl/twiSync.sv
module twiSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '1;
        else       pipe <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '1;
        else       pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/twiDatapath.sv
module twiDatapath
  import twiPkg::*;
#(
  parameter int         REG_COUNT   = 16,
  parameter int         BUSY_CYCLES = 1000,
  parameter logic [3:0] DEV_HI      = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic [2:0] strap,
  input  dpStrobe_t st,
  output busEvent_t ev,
  output logic      rxRw,
  output logic      txMsb,
  output logic      addrMatch,
  output logic      busy
);
  localparam int PTR_W  = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam int LINES  = 2;

  logic [LINES-1:0] rawLines, syncLines;
  assign rawLines = {sclIn, sdaIn};

  genvar gi;
  generate
    for (gi = 0; gi < LINES; gi++) begin : g_sync
      twiSync #(.STAGES(SYNC_STAGES)) uSync (
        .clk (clk),
        .rstN(rstN),
        .din (rawLines[gi]),
        .dout(syncLines[gi])
      );
    end
  endgenerate

  logic sclNow, sdaNow, sclPrev, sdaPrev;
  assign sclNow = syncLines[1];
  assign sdaNow = syncLines[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  always_comb begin
    ev.start    = sclNow & sclPrev & sdaPrev & ~sdaNow;
    ev.stop     = sclNow & sclPrev & ~sdaPrev & sdaNow;
    ev.sclRise  = sclNow & ~sclPrev;
    ev.sclFall  = ~sclNow & sclPrev;
    ev.sdaBit   = sdaNow;
    ev.sclLevel = sclNow;
  end

  // receive shifter
  logic [7:0] rxReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rxReg <= '0;
    else if (st.rxShift) rxReg <= {rxReg[6:0], sdaNow};
  end
  assign rxRw      = rxReg[0];
  assign addrMatch = (rxReg[7:1] == {DEV_HI, strap});

  // pointer and register file
  logic [PTR_W-1:0] ptr, ptrNext;
  logic [7:0]       regFile [REG_COUNT];
  logic [7:0]       txReg;

  assign ptrNext = (ptr == PTR_W'(REG_COUNT - 1)) ? '0 : ptr + PTR_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (st.ptrLoad) begin
      ptr <= rxReg[PTR_W-1:0];
    end else if (st.regWrite || st.txLoad) begin
      ptr <= ptrNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regFile[i] <= '0;
    end else if (st.regWrite) begin
      regFile[ptr] <= rxReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           txReg <= '0;
    else if (st.txLoad)  txReg <= regFile[ptr];
    else if (st.txShift) txReg <= {txReg[6:0], 1'b0};
  end
  assign txMsb = txReg[7];

  // commit lockout window
  logic [BUSY_W-1:0] busyCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                busyCnt <= '0;
    else if (st.busyArm)      busyCnt <= BUSY_W'(BUSY_CYCLES);
    else if (busyCnt != '0)   busyCnt <= busyCnt - BUSY_W'(1);
  end
  assign busy = (busyCnt != '0);

  // R7
  busy_arm_on_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.busyArm |-> ev.stop);

  // R5
  ptr_step_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.regWrite && !st.ptrLoad && ptr == PTR_W'(REG_COUNT - 1)) |=> ptr == '0);

endmodule

// File: rtl/twiControl.sv
module twiControl
  import twiPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  busEvent_t ev,
  input  logic      rxRw,
  input  logic      txMsb,
  input  logic      addrMatch,
  input  logic      busy,
  output dpStrobe_t st,
  output logic      sdaDriveLow
);
  twiState_e state, stateN;
  byteKind_e kind, kindN;
  logic [3:0] bitCnt, bitN;
  logic rwRead, rwN, wroteData, wroteN, masterAck, ackN, driveLow, driveN;

  always_comb begin
    stateN = state;
    kindN  = kind;
    bitN   = bitCnt;
    rwN    = rwRead;
    wroteN = wroteData;
    ackN   = masterAck;
    driveN = driveLow;
    st     = '0;

    if (ev.stop) begin
      stateN = ST_IDLE;
      driveN = 1'b0;
      wroteN = 1'b0;
      if (wroteData) st.busyArm = 1'b1;
    end else if (ev.start) begin
      stateN = ST_RX;
      kindN  = BK_ADDR;
      bitN   = '0;
      driveN = 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (ev.sclRise && bitCnt < 4'd8) begin
            st.rxShift = 1'b1;
            bitN       = bitCnt + 4'd1;
          end else if (ev.sclFall && bitCnt == 4'd8) begin
            case (kind)
              BK_ADDR: begin
                if (addrMatch && !busy) begin
                  rwN    = rxRw;
                  driveN = 1'b1;
                  stateN = ST_ACKOUT;
                end else begin
                  stateN = ST_IDLE;
                end
              end
              BK_MEM: begin
                st.ptrLoad = 1'b1;
                driveN     = 1'b1;
                stateN     = ST_ACKOUT;
              end
              default: begin
                st.regWrite = 1'b1;
                wroteN      = 1'b1;
                driveN      = 1'b1;
                stateN      = ST_ACKOUT;
              end
            endcase
          end
        end
        ST_ACKOUT: begin
          if (ev.sclFall) begin
            bitN = '0;
            if (kind == BK_ADDR && rwRead) begin
              st.txLoad = 1'b1;
              stateN    = ST_TX;
            end else begin
              driveN = 1'b0;
              kindN  = (kind == BK_ADDR) ? BK_MEM : BK_DATA;
              stateN = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (ev.sclRise) begin
            bitN = bitCnt + 4'd1;
          end else if (ev.sclFall) begin
            if (bitCnt == 4'd8) begin
              driveN = 1'b0;
              stateN = ST_ACKIN;
            end else begin
              st.txShift = 1'b1;
            end
          end else if (!ev.sclLevel) begin
            driveN = ~txMsb;
          end
        end
        ST_ACKIN: begin
          if (ev.sclRise) begin
            ackN = ~ev.sdaBit;
          end else if (ev.sclFall) begin
            bitN = '0;
            if (masterAck) begin
              st.txLoad = 1'b1;
              stateN    = ST_TX;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kind      <= BK_ADDR;
      bitCnt    <= '0;
      rwRead    <= 1'b0;
      wroteData <= 1'b0;
      masterAck <= 1'b0;
      driveLow  <= 1'b0;
    end else begin
      state     <= stateN;
      kind      <= kindN;
      bitCnt    <= bitN;
      rwRead    <= rwN;
      wroteData <= wroteN;
      masterAck <= ackN;
      driveLow  <= driveN;
    end
  end

  assign sdaDriveLow = driveLow;

  // R9
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !ev.sclLevel);

  // R2
  addr_ack_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaDriveLow) && state == ST_ACKOUT && kind == BK_ADDR)
      |-> ($past(addrMatch) && !$past(busy)));

  // R6
  release_master_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_ACKIN |-> !sdaDriveLow);

  // R4
  write_in_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.regWrite |-> !rwRead);

endmodule

// File: rtl/twiRegSlave.sv
module twiRegSlave
  import twiPkg::*;
#(
  parameter int         REG_COUNT   = 16,
  parameter int         BUSY_CYCLES = 1000,
  parameter logic [3:0] DEV_HI      = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strap,
  output logic       sdaDriveLow
);
  dpStrobe_t st;
  busEvent_t ev;
  logic rxRw, txMsb, addrMatch, busy;

  twiDatapath #(
    .REG_COUNT  (REG_COUNT),
    .BUSY_CYCLES(BUSY_CYCLES),
    .DEV_HI     (DEV_HI),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .strap    (strap),
    .st       (st),
    .ev       (ev),
    .rxRw     (rxRw),
    .txMsb    (txMsb),
    .addrMatch(addrMatch),
    .busy     (busy)
  );

  twiControl uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .ev         (ev),
    .rxRw       (rxRw),
    .txMsb      (txMsb),
    .addrMatch  (addrMatch),
    .busy       (busy),
    .st         (st),
    .sdaDriveLow(sdaDriveLow)
  );
endmodule

// File: tb/sim_twiRegSlave.sv
module sim_twiRegSlave;
  localparam int H = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sdaLow;
  logic sdaBus;
  assign sdaBus = sdaM & ~sdaLow;

  twiRegSlave u0 (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclM),
    .sdaIn      (sdaBus),
    .strap      (strap),
    .sdaDriveLow(sdaLow)
  );

  typedef struct {
    string      req;
    logic [7:0] val;
  } item_t;

  item_t expQ[$];
  item_t obsQ[$];
  int checks = 0;
  int fails = 0;
  int unstable = 0;
  bit done = 1'b0;

  // monitor: pair expectations with observations
  always @(negedge clk) begin
    while (expQ.size() > 0 && obsQ.size() > 0) begin
      item_t e;
      item_t o;
      e = expQ.pop_front();
      o = obsQ.pop_front();
      checks++;
      if (e.val !== o.val) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", e.req, o.val, e.val);
      end
    end
  end

  task automatic hw();
    repeat (H) @(negedge clk);
  endtask

  task automatic expectItem(input string req, input logic [7:0] v);
    expQ.push_back('{req, v});
  endtask

  task automatic observe(input logic [7:0] v);
    obsQ.push_back('{"", v});
  endtask

  task automatic wbit(input logic b);
    sdaM = b; hw();
    sclM = 1'b1; hw();
    sclM = 1'b0; hw();
  endtask

  // sample slave data during the high phase; it must stay constant (R9)
  task automatic rbit(output logic b);
    logic first;
    sdaM = 1'b1; hw();
    sclM = 1'b1;
    @(negedge clk);
    first = sdaBus;
    for (int k = 1; k < H; k++) begin
      @(negedge clk);
      if (sdaBus !== first) unstable++;
      if (k == H / 2) b = sdaBus;
    end
    sclM = 1'b0; hw();
  endtask

  task automatic startC();
    sdaM = 1'b1; hw();
    sclM = 1'b1; hw();
    sdaM = 1'b0; hw();
    sclM = 1'b0; hw();
  endtask

  task automatic stopC();
    sdaM = 1'b0; hw();
    sclM = 1'b1; hw();
    sdaM = 1'b1; hw();
  endtask

  // expAck: 1 means the slave should acknowledge (line low)
  task automatic sendByte(input logic [7:0] v, input string req, input logic expAck);
    logic b;
    expectItem(req, {7'b0, ~expAck});
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    observe({7'b0, b});
  endtask

  task automatic recvByte(input logic [7:0] expV, input string req, input logic giveAck);
    logic [7:0] got;
    logic b;
    expectItem(req, expV);
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      got[i] = b;
    end
    observe(got);
    wbit(~giveAck);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (10) @(negedge clk);

    // R1: released after reset
    expectItem("R1", 8'h00);
    observe({7'b0, sdaLow});

    // R3: strap bits differ -> silent, nothing stored
    startC();
    sendByte(8'hA8, "R3", 1'b0);
    sendByte(8'h03, "R3", 1'b0);
    sendByte(8'hFF, "R3", 1'b0);
    stopC();

    // R2 R4: write 0xC6 to register 3
    startC();
    sendByte(8'hAA, "R2", 1'b1);
    sendByte(8'h03, "R4", 1'b1);
    sendByte(8'hC6, "R4", 1'b1);
    stopC();

    // R7: poll during the commit window -> no ack
    startC();
    sendByte(8'hAA, "R7", 1'b0);
    stopC();
    repeat (1200) @(negedge clk);

    // R7 R6 R3: after window, acked; read back register 3
    startC();
    sendByte(8'hAA, "R7", 1'b1);
    sendByte(8'h03, "R4", 1'b1);
    startC();
    sendByte(8'hAB, "R6", 1'b1);
    recvByte(8'hC6, "R6 R3", 1'b0);
    stopC();

    // R8: pointer-only write left no lockout
    startC();
    sendByte(8'hAA, "R8", 1'b1);
    stopC();

    // R5: write across the wrap
    startC();
    sendByte(8'hAA, "R2", 1'b1);
    sendByte(8'h0E, "R4", 1'b1);
    sendByte(8'h11, "R5", 1'b1);
    sendByte(8'h22, "R5", 1'b1);
    sendByte(8'h33, "R5", 1'b1);
    stopC();
    repeat (1200) @(negedge clk);

    // R5 R6 R1: read across the wrap, register 1 still zero
    startC();
    sendByte(8'hAA, "R2", 1'b1);
    sendByte(8'h0E, "R4", 1'b1);
    startC();
    sendByte(8'hAB, "R6", 1'b1);
    recvByte(8'h11, "R5", 1'b1);
    recvByte(8'h22, "R5", 1'b1);
    recvByte(8'h33, "R5", 1'b1);
    recvByte(8'h00, "R1", 1'b0);
    stopC();
    expectItem("R6", 8'h00);
    observe({7'b0, sdaLow});

    // R2: strap change moves the address
    strap = 3'b010;
    repeat (4) @(negedge clk);
    startC();
    sendByte(8'hAA, "R2", 1'b0);
    stopC();
    startC();
    sendByte(8'hA4, "R2", 1'b1);
    sendByte(8'h00, "R4", 1'b1);
    startC();
    sendByte(8'hA5, "R2", 1'b1);
    recvByte(8'h33, "R2", 1'b0);
    stopC();

    // R9: slave data held steady across every high phase
    expectItem("R9", 8'h00);
    observe(8'(unstable));

    repeat (20) @(negedge clk);
    if (expQ.size() != 0 || obsQ.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL scoreboard actual=%0d/%0d expected=0/0", expQ.size(), obsQ.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule